// File: doc/BRIEF.md
# Comparator Output Debounce Filter

This block cleans up the digital output of one analog comparator before it reaches a pin or an interrupt edge detector. A new level on the comparator bit is accepted only after it has been seen on a programmed number of consecutive sample ticks. Any sample that agrees with the current output throws away the partial count. The sample ticks run at the system clock rate or at a slower rate set by a small prescaler. The two settings together cover windows from 1 to 256 clock periods.

The filter length is a power of two picked by a 3-bit code. Code zero turns the filter off, so the registered output then follows the input on every clock. A polarity control is applied to the raw bit before anything else. A pin selector then shows either that corrected raw bit or the filtered result.

Control is held in a four-state machine:
- `ST_OFF`: the channel is disabled.
- `ST_PASS`: filtering is turned off.
- `ST_HOLD`: filtering is on and no change is pending.
- `ST_QUAL`: a new level is being counted.

Transitions:
- Any state goes to `ST_OFF` when enable drops.
- `ST_OFF` and `ST_PASS` go to `ST_HOLD` once filtering is active.
- `ST_HOLD` goes to `ST_QUAL` on a tick whose sample differs from the output.
- `ST_QUAL` goes back to `ST_HOLD` when the count completes and the output flips.
- `ST_QUAL` also goes back to `ST_HOLD` when a tick brings a sample equal to the output.
- Any state goes to `ST_PASS` while the count code is zero.
- Any state goes to `ST_HOLD` (or `ST_PASS`) on an edge where a select input changed.

Top module: `cmp_glitch_filter`

## Requirements
- R1: While `enable` is 0 (and during reset), `filt_out` is 0. The counter and prescaler are also held clear.
- R2: With `count_sel` = 0, each clock edge loads `raw_in ^ invert` into `filt_out`, so the output follows the input one cycle later.
- R3: With `count_sel` = k, where k is 1 to 7, `filt_out` takes a new level on the sample tick that completes 2^(k-1) consecutive ticks whose sample differs from `filt_out`. That is 1, 2, 4, 8, 16, 32 or 64 ticks.
- R4: A tick whose sample equals the current `filt_out` resets the consecutive count to zero.
- R5: `div_sel` sets the tick spacing: 0 gives every clock, 1 every 2nd clock, 2 every 4th clock, and 3 every clock. The first tick after a restart falls on the spacing-th edge. So code 7 with `div_sel` 2 needs 256 edges, and with `div_sel` 1 needs 128 edges. `filt_out` never changes on an edge without a tick.
- R6: On an edge where `count_sel` or `div_sel` differs from its value at the previous edge, the count and the prescaler are cleared and `filt_out` holds. Select registers reset to 0.
- R7: `pin_out` equals `raw_in ^ invert` combinationally when `pin_sel` is 0, and equals `filt_out` when `pin_sel` is 1.
- R8: Inversion is applied before the filter. With `invert` = 1 and a steady `raw_in` of 0, an enabled filter settles to `filt_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low clears the filtered value |
| raw_in | input | 1 | Raw comparator decision bit |
| count_sel | input | 3 | Filter length code (0 = bypass, k = 2^(k-1) samples) |
| div_sel | input | 2 | Sample tick divider code |
| pin_sel | input | 1 | 0 = raw path to pin, 1 = filtered path to pin |
| invert | input | 1 | Flip the comparator polarity |
| filt_out | output | 1 | Filtered comparator value |
| pin_out | output | 1 | Pin-facing output |

## Verification
The bench goes after four kinds of fault.
- A one-sample glitch in the middle of a count. A filter that does not restart would accept the new level early.
- A select change partway through a count. A design that keeps a partial count would flip a few edges too soon.
- The longest windows with the divided tick, at exactly 255 and 256 edges (and 127 and 128). An off-by-one prescaler would flip one tick early or late.
- Inversion placed after the filter. The filtered path would then settle to the wrong polarity.

Long random runs mix enable drops, polarity changes and select changes against a cycle-level model of the rules.

// File: rtl/cgf_pkg.sv
package cgf_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PASS = 2'd1,
        ST_HOLD = 2'd2,
        ST_QUAL = 2'd3
    } cgf_state_e;

endpackage

// File: rtl/cgf_sel_watch.sv
// Detects a change of either select input relative to the previous edge.
module cgf_sel_watch #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] count_sel,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              sel_chg
);
    logic [CODE_W-1:0] count_q;
    logic [DIV_W-1:0]  div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            div_q   <= '0;
        end else begin
            count_q <= count_sel;
            div_q   <= div_sel;
        end
    end

    assign sel_chg = (count_sel != count_q) || (div_sel != div_q);

endmodule

// File: rtl/cgf_prescaler.sv
// Sample tick generator: a tick every 2^div_sel clocks; the all-ones code runs at full rate.
module cgf_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int NUM_DIV = 1 << DIV_W;
    localparam int PRE_RAW = NUM_DIV - 2;
    localparam int PRE_W   = (PRE_RAW < 1) ? 1 : PRE_RAW;

    logic [PRE_W-1:0] lim_tbl [NUM_DIV];
    logic [PRE_W-1:0] lim;
    logic [PRE_W-1:0] pcnt;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lim
        localparam int L = (g == NUM_DIV - 1) ? 0 : ((1 << g) - 1);
        assign lim_tbl[g] = PRE_W'(L);
    end

    assign lim  = lim_tbl[div_sel];
    assign tick = run && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt <= lim)); // R5

endmodule

// File: rtl/cgf_qualifier.sv
// Consecutive-sample qualification state machine and filtered output register.
module cgf_qualifier
    import cgf_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sel_chg,
    input  logic              tick,
    input  logic              samp,
    input  logic [CODE_W-1:0] count_sel,
    output logic              filt
);
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int CNT_RAW   = NUM_CODES - 2;
    localparam int CNT_W     = (CNT_RAW < 1) ? 1 : CNT_RAW;

    cgf_state_e       st_q, st_n;
    logic             filt_q, filt_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] need_m1_tbl [NUM_CODES];
    logic [CNT_W-1:0] need_m1;
    logic             bypass;

    // step results for a sample tick while filtering
    cgf_state_e       step_st;
    logic             step_filt;
    logic [CNT_W-1:0] step_cnt;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_need
        localparam int N1 = (g == 0) ? 0 : ((1 << (g - 1)) - 1);
        assign need_m1_tbl[g] = CNT_W'(N1);
    end

    assign need_m1 = need_m1_tbl[count_sel];
    assign bypass  = (count_sel == '0);

    always_comb begin
        step_st   = ST_HOLD;
        step_filt = filt_q;
        step_cnt  = '0;
        if (samp == filt_q) begin
            step_st = ST_HOLD;              // agreeing sample restarts the run
        end else if (cnt_q == need_m1) begin
            step_filt = samp;               // run complete: accept new level
            step_st   = ST_HOLD;
        end else begin
            step_cnt = cnt_q + 1'b1;
            step_st  = ST_QUAL;
        end
    end

    always_comb begin
        st_n   = st_q;
        filt_n = filt_q;
        cnt_n  = cnt_q;
        if (!enable) begin
            st_n   = ST_OFF;
            filt_n = 1'b0;
            cnt_n  = '0;
        end else if (sel_chg) begin
            st_n  = bypass ? ST_PASS : ST_HOLD;
            cnt_n = '0;
        end else if (bypass) begin
            st_n   = ST_PASS;
            filt_n = samp;
            cnt_n  = '0;
        end else begin
            unique case (st_q)
                ST_OFF, ST_PASS: begin
                    if (tick) begin
                        st_n   = step_st;
                        filt_n = step_filt;
                        cnt_n  = step_cnt;
                    end else begin
                        st_n  = ST_HOLD;
                        cnt_n = '0;
                    end
                end
                ST_HOLD, ST_QUAL: begin
                    if (tick) begin
                        st_n   = step_st;
                        filt_n = step_filt;
                        cnt_n  = step_cnt;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_n;
    end

    // output and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            filt_q <= filt_n;
            cnt_q  <= cnt_n;
        end
    end

    assign filt = filt_q;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!filt_q && st_q == ST_OFF)); // R1
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sel_chg && bypass) |=> (filt_q == $past(samp))); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_chg |-> (cnt_q <= need_m1)); // R3
    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sel_chg && !bypass && tick && samp == filt_q) |=> (cnt_q == '0)); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sel_chg && !bypass && !tick) |=> $stable(filt_q)); // R5
    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sel_chg) |=> (cnt_q == '0 && $stable(filt_q))); // R6

endmodule

// File: rtl/cgf_pin_mux.sv
// Chooses the pin-facing value between the polarity-corrected raw bit and the filtered bit.
module cgf_pin_mux (
    input  logic pin_sel,
    input  logic raw_pol,
    input  logic filt,
    output logic pin_out
);
    always_comb begin
        unique case (pin_sel)
            1'b0: pin_out = raw_pol;
            1'b1: pin_out = filt;
        endcase
    end
endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              raw_in,
    input  logic [CODE_W-1:0] count_sel,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              pin_sel,
    input  logic              invert,
    output logic              filt_out,
    output logic              pin_out
);
    logic samp;
    logic sel_chg;
    logic run;
    logic tick;

    assign samp = raw_in ^ invert;   // polarity applied ahead of the filter (R8)
    assign run  = enable && !sel_chg && (count_sel != '0);

    cgf_sel_watch #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_sel (count_sel),
        .div_sel   (div_sel),
        .sel_chg   (sel_chg)
    );

    cgf_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_sel (div_sel),
        .tick    (tick)
    );

    cgf_qualifier #(.CODE_W(CODE_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sel_chg   (sel_chg),
        .tick      (tick),
        .samp      (samp),
        .count_sel (count_sel),
        .filt      (filt_out)
    );

    cgf_pin_mux u_mux (
        .pin_sel (pin_sel),
        .raw_pol (samp),
        .filt    (filt_out),
        .pin_out (pin_out)
    );

endmodule

// File: tb/cmp_glitch_filter_tb.sv
module cmp_glitch_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       raw_in = 1'b0;
    logic [2:0] count_sel = '0;
    logic [1:0] div_sel = '0;
    logic       pin_sel = 1'b0;
    logic       invert = 1'b0;
    logic       filt_out;
    logic       pin_out;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    // reference model state
    logic       m_filt = 1'b0;
    int         m_cnt = 0;
    int         m_pc = 0;
    logic [2:0] m_cs_q = '0;
    logic [1:0] m_ds_q = '0;

    always #10 clk = ~clk;   // 50 MHz

    cmp_glitch_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .raw_in    (raw_in),
        .count_sel (count_sel),
        .div_sel   (div_sel),
        .pin_sel   (pin_sel),
        .invert    (invert),
        .filt_out  (filt_out),
        .pin_out   (pin_out)
    );

    function automatic int need_of(input logic [2:0] cs);
        return 1 << (cs - 1);
    endfunction

    function automatic int lim_of(input logic [1:0] ds);
        case (ds)
            2'd1:    return 1;
            2'd2:    return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic pin_exp(input logic ps, input logic r, input logic iv, input logic f);
        return ps ? f : (r ^ iv);
    endfunction

    // model advances on each edge from the stable inputs
    always @(posedge clk) begin
        logic chg;
        logic s;
        logic tk;
        if (!rst_n) begin
            m_filt = 1'b0; m_cnt = 0; m_pc = 0; m_cs_q = '0; m_ds_q = '0;
        end else begin
            chg = (count_sel != m_cs_q) || (div_sel != m_ds_q);
            m_cs_q = count_sel;
            m_ds_q = div_sel;
            s = raw_in ^ invert;
            if (!enable) begin
                m_filt = 1'b0; m_cnt = 0; m_pc = 0;
            end else if (chg) begin
                m_cnt = 0; m_pc = 0;
            end else if (count_sel == 3'd0) begin
                m_filt = s; m_cnt = 0; m_pc = 0;
            end else begin
                tk = (m_pc == lim_of(div_sel));
                m_pc = tk ? 0 : m_pc + 1;
                if (tk) begin
                    if (s == m_filt) m_cnt = 0;
                    else if (m_cnt + 1 == need_of(count_sel)) begin
                        m_filt = s; m_cnt = 0;
                    end else m_cnt = m_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // advance one edge, then compare against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        chk(phase, "filt_out/model", filt_out, m_filt);
        chk("R7", "pin_out/model", pin_out, pin_exp(pin_sel, raw_in, invert, m_filt));
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(150000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        pin_sel = 1'b1;
        settle(4);
        // R1: reset state
        chk("R1", "filt_out after reset", filt_out, 1'b0);
        chk("R1", "pin_out after reset", pin_out, 1'b0);
        rst_n = 1'b1;
        settle(2);

        // R2: bypass follows input one edge later
        phase = "R2";
        enable = 1'b1; count_sel = 3'd0; div_sel = 2'd0;
        settle(3);
        raw_in = 1'b1; cyc();
        chk("R2", "bypass rise", filt_out, 1'b1);
        raw_in = 1'b0; cyc();
        chk("R2", "bypass fall", filt_out, 1'b0);

        // R3: one-sample and two-sample codes
        phase = "R3";
        count_sel = 3'd1; settle(4);
        raw_in = 1'b1; cyc();
        chk("R3", "code1 accepts on first tick", filt_out, 1'b1);
        count_sel = 3'd2; raw_in = 1'b0; cyc();
        cyc();
        chk("R3", "code2 holds after one sample", filt_out, 1'b1);
        cyc();
        chk("R3", "code2 flips after two samples", filt_out, 1'b0);

        // R4: glitch in the middle of a four-sample run restarts it
        phase = "R4";
        count_sel = 3'd3; settle(6);
        raw_in = 1'b1; settle(3);
        raw_in = 1'b0; cyc();
        raw_in = 1'b1; settle(3);
        chk("R4", "restart after agreeing sample", filt_out, 1'b0);
        cyc();
        chk("R4", "flip after full run", filt_out, 1'b1);

        // R6: select change mid-run clears the partial count
        phase = "R6";
        raw_in = 1'b0; settle(8);
        chk("R6", "settled low", filt_out, 1'b0);
        raw_in = 1'b1; settle(3);
        div_sel = 2'd3; cyc();
        settle(3);
        chk("R6", "no carry-over of partial count", filt_out, 1'b0);
        cyc();
        chk("R6", "flip after fresh run", filt_out, 1'b1);

        // R5: longest spans with divided ticks
        phase = "R5";
        count_sel = 3'd7; div_sel = 2'd2; raw_in = 1'b0; settle(300);
        chk("R5", "settled low", filt_out, 1'b0);
        div_sel = 2'd3; cyc();
        div_sel = 2'd2; raw_in = 1'b1; cyc();
        settle(255);
        chk("R5", "div4 not yet at 255", filt_out, 1'b0);
        cyc();
        chk("R5", "div4 flips at 256", filt_out, 1'b1);
        div_sel = 2'd1; raw_in = 1'b0; cyc();
        settle(127);
        chk("R5", "div2 not yet at 127", filt_out, 1'b1);
        cyc();
        chk("R5", "div2 flips at 128", filt_out, 1'b0);
        div_sel = 2'd3; raw_in = 1'b1; cyc();
        settle(63);
        chk("R5", "code 11 not yet at 63", filt_out, 1'b0);
        cyc();
        chk("R5", "code 11 acts as full rate", filt_out, 1'b1);

        // R1: disable clears
        phase = "R1";
        enable = 1'b0; cyc();
        chk("R1", "disable clears filt_out", filt_out, 1'b0);

        // R7: raw path is combinational
        pin_sel = 1'b0; raw_in = 1'b1; invert = 1'b0; #1;
        chk("R7", "raw path", pin_out, 1'b1);
        invert = 1'b1; #1;
        chk("R7", "raw path inverted", pin_out, 1'b0);
        pin_sel = 1'b1; #1;
        chk("R7", "filtered path while off", pin_out, 1'b0);

        // R8: inversion ahead of the filter
        phase = "R8";
        enable = 1'b1; count_sel = 3'd1; div_sel = 2'd0; raw_in = 1'b0; invert = 1'b1;
        settle(5);
        chk("R8", "inverted steady low settles high", filt_out, 1'b1);
        chk("R8", "pin shows inverted filter", pin_out, 1'b1);

        // random mix against the model
        phase = "R3/R4/R5/R6 random";
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 63) == 0)  count_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 127) == 0) div_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 255) == 0) enable = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 31) == 0)  pin_sel = ~pin_sel;
            if ($urandom_range(0, 199) == 0) invert = ~invert;
            if ($urandom_range(0, 9) == 0)   raw_in = ~raw_in;
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule